// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block recovers characters from an asynchronous serial line. The line rests at mark (logic 1), and each character starts with a space (logic 0). A free-running enable `tick` pulses sixteen times per bit period, and the receiver times every sample from it. The raw line first passes through a two-flop synchronizer. A falling edge only counts as a start bit if the line is still space half a bit later. The receiver then samples each data bit, the optional parity bit and the first stop bit once, at the bit's midpoint.

The character format is taken from static configuration inputs:
- five to eight data bits, sent least significant bit first;
- parity off, even, odd, or stick (a fixed parity value);
- any stop length, because only the first stop bit is examined.

Each finished frame produces a one-cycle report. A normal character comes with a valid pulse, which may carry parity-error and framing-error flags. A frame in which every sample was space is reported on a separate break pulse, so it is never mistaken for a null character. After a framing error or a break, the receiver waits for the line to return to mark before it arms again.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset, `rx_valid`, `rx_perr`, `rx_ferr` and `rx_break` are all 0 and the receiver is idle, looking for a start bit.
- R2: A space on the synchronized line seen on a `tick` opens a start check. If the line is back at mark on the 8th following tick, the receiver returns to idle and reports nothing.
- R3: The data width is 5 + `cfg_bits` bits (code 0..3 gives 5..8). Bits arrive least significant bit first and fill `rx_data` from bit 0 upward. The unused upper bits of `rx_data` read 0.
- R4: With `cfg_par_en`=1 and `cfg_par_stick`=0, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity, counting the ones in the data plus the parity bit. A mismatch sets `rx_perr` together with `rx_valid`. With `cfg_par_en`=0, `rx_perr` stays 0 and no parity bit is expected.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=1, the expected parity bit equals `cfg_par_odd` whatever the data. Any other value sets `rx_perr`.
- R6: If the first stop sample is space and the frame is not a break, `rx_valid` pulses with `rx_ferr`=1. Only the first stop bit is checked, so frames with 1.5 or 2 stop bits are accepted as normal frames.
- R7: If the start, data, parity (when enabled) and stop samples are all space, `rx_break` pulses alone, with `rx_valid`, `rx_perr` and `rx_ferr` at 0. A null character with a mark stop bit is reported as valid data 0.
- R8: After a framing error or a break, no new start is accepted until the synchronized line has returned to mark.
- R9: Each frame raises its report for exactly one clock cycle. That cycle follows the clock edge of the stop-bit sample. No report appears at any other time.
- R10: The start bit is sampled 8 ticks after the tick that saw the falling edge. Each later bit is sampled 16 ticks after the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, 1 = mark |
| cfg_bits | input | 2 | Data width code, width = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity; in stick mode, the fixed parity value |
| cfg_par_stick | input | 1 | Stick parity mode |
| rx_data | output | 8 | Received character, zero-filled above the data width |
| rx_valid | output | 1 | One-cycle pulse: character received |
| rx_perr | output | 1 | Parity error, qualified by rx_valid |
| rx_ferr | output | 1 | Framing error, qualified by rx_valid |
| rx_break | output | 1 | One-cycle pulse: break frame received |

## Verification
A line edge reaches the state machine two clocks after the line changes, because of the synchronizer. The edge is caught on the next tick. The frame report is then due one clock after the tick lying 8 + 16*(1 + data bits + parity bit) ticks after that detecting tick. The bench drives every falling edge so that the detecting tick lands on a known clock edge. It computes this due cycle and queues the expected report for it. On every clock it compares all four report outputs, either against the queued report or against silence. A false start, a held-low line after a framing error, and a break must therefore produce exactly the predicted pulses and nothing else.

// File: rtl/serial_rx_brk_pkg.sv
package serial_rx_brk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT_MARK
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rx_par_exp.sv
module rx_par_exp #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         odd,
    input  logic         stick,
    output logic         exp_bit
);
    // even: parity bit makes the total count even; odd flips it; stick forces the odd flag
    always_comb begin
        if (stick) exp_bit = odd;
        else       exp_bit = (^data) ^ odd;
    end
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
    import serial_rx_brk_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int MAXB        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rx_line,
    input  logic [1:0]      cfg_bits,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            cfg_par_stick,
    output logic [MAXB-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_perr,
    output logic            rx_ferr,
    output logic            rx_break
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int IW   = $clog2(MAXB);
    localparam int BASE = MAXB - 3;

    typedef struct packed {
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [IW-1:0]   idx;
        logic [MAXB-1:0] shf;
        logic            seen1;
        logic            pbad;
        logic [MAXB-1:0] dout;
        logic            vld;
        logic            perr;
        logic            ferr;
        logic            brk;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic     rxs;
    logic     par_exp;
    logic [IW-1:0] last_idx;
    logic     smp_mid;
    logic     smp_full;

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rxs)
    );

    rx_par_exp #(.W(MAXB)) u_par (
        .data    (r_q.shf),
        .odd     (cfg_par_odd),
        .stick   (cfg_par_stick),
        .exp_bit (par_exp)
    );

    assign last_idx = IW'(BASE - 1) + IW'(cfg_bits);
    assign smp_mid  = tick && (r_q.cnt == CW'(HALF - 1));
    assign smp_full = tick && (r_q.cnt == CW'(OVS - 1));

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.perr = 1'b0;
        r_d.ferr = 1'b0;
        r_d.brk  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tick && !rxs) begin
                    r_d.st  = ST_START;
                    r_d.cnt = '0;
                end
            end
            ST_START: begin
                if (smp_mid) begin
                    if (rxs) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st    = ST_DATA;
                        r_d.cnt   = '0;
                        r_d.idx   = '0;
                        r_d.shf   = '0;
                        r_d.seen1 = 1'b0;
                        r_d.pbad  = 1'b0;
                    end
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (smp_full) begin
                    r_d.cnt          = '0;
                    r_d.shf[r_q.idx] = rxs;
                    r_d.seen1        = r_q.seen1 | rxs;
                    if (r_q.idx == last_idx) r_d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    else                     r_d.idx = r_q.idx + 1'b1;
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (smp_full) begin
                    r_d.cnt   = '0;
                    r_d.pbad  = (rxs != par_exp);
                    r_d.seen1 = r_q.seen1 | rxs;
                    r_d.st    = ST_STOP;
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (smp_full) begin
                    r_d.cnt = '0;
                    if (rxs) begin
                        r_d.vld  = 1'b1;
                        r_d.perr = cfg_par_en & r_q.pbad;
                        r_d.dout = r_q.shf;
                        r_d.st   = ST_IDLE;
                    end else if (!r_q.seen1) begin
                        r_d.brk = 1'b1;
                        r_d.st  = ST_WAIT_MARK;
                    end else begin
                        r_d.vld  = 1'b1;
                        r_d.ferr = 1'b1;
                        r_d.perr = cfg_par_en & r_q.pbad;
                        r_d.dout = r_q.shf;
                        r_d.st   = ST_WAIT_MARK;
                    end
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT_MARK: begin
                if (rxs) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data  = r_q.dout;
    assign rx_valid = r_q.vld;
    assign rx_perr  = r_q.perr;
    assign rx_ferr  = r_q.ferr;
    assign rx_break = r_q.brk;
endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk #(
    parameter int MAXB = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cfg_bits,
    input logic            cfg_par_en,
    input logic [MAXB-1:0] rx_data,
    input logic            rx_valid,
    input logic            rx_perr,
    input logic            rx_ferr,
    input logic            rx_break
);
    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r9_break_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> !rx_break);

    a_r7_break_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |-> (!rx_valid && !rx_perr && !rx_ferr));

    a_r4_perr_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rx_perr |-> (rx_valid && cfg_par_en));

    a_r6_ferr_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |-> rx_valid);

    a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_bits == 2'd0) |-> (rx_data[MAXB-1:MAXB-3] == 3'b000));
endmodule

bind serial_rx_brk serial_rx_brk_chk #(.MAXB(MAXB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bits   (cfg_bits),
    .cfg_par_en (cfg_par_en),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .rx_break   (rx_break)
);

// File: tb/sim_serial_rx_brk.sv
`timescale 1ns/1ps
module sim_serial_rx_brk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_bits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_break;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int       due;
        logic [7:0] d;
        bit       v, pe, fe, bk;
    } ev_t;
    ev_t evq[$];

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign tick = (cyc % 4 == 0);

    serial_rx_brk u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_par_stick(cfg_par_stick), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    // per-clock comparison against queued reports or silence
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (evq.size() > 0 && evq[0].due == cyc) begin
                ev_t e;
                e = evq.pop_front();
                chk(rx_valid == e.v, "R9 valid pulse", int'(rx_valid), int'(e.v));
                chk(rx_break == e.bk, "R7 break pulse", int'(rx_break), int'(e.bk));
                chk(rx_perr == e.pe, "R4/R5 parity flag", int'(rx_perr), int'(e.pe));
                chk(rx_ferr == e.fe, "R6 framing flag", int'(rx_ferr), int'(e.fe));
                if (e.v) chk(rx_data == e.d, "R3 data", int'(rx_data), int'(e.d));
            end else begin
                chk({rx_valid, rx_perr, rx_ferr, rx_break} == 4'b0,
                    "R9/R8/R2 no report expected", int'({rx_valid, rx_perr, rx_ferr, rx_break}), 0);
            end
        end
    end

    // frame: nd data bits of val, optional parity bit pbit, stop value, stop length, extra low time
    task automatic frame(input int nd, input logic [7:0] val, input bit pbit,
                         input bit stopv, input int stop_clks, input int extra_low);
        int ones = 0;
        bit np = cfg_par_en;
        bit expp;
        ev_t e;
        logic [7:0] m = 8'((1 << nd) - 1);
        for (int i = 0; i < nd; i++) ones += int'(val[i]);
        if (cfg_par_stick) expp = cfg_par_odd;
        else expp = ((ones % 2) == 1) ^ cfg_par_odd;
        // align so that the detecting tick is two clocks after the line change
        step(1);
        while (cyc % 4 != 2) step(1);
        e.due = cyc + 2 + 32 + 64 * (1 + nd + int'(np)) + 1;
        e.d   = val & m;
        e.bk  = (!stopv) && ((val & m) == 0) && (!np || !pbit);
        e.v   = !e.bk;
        e.fe  = e.v && !stopv;
        e.pe  = e.v && np && (pbit != expp);
        evq.push_back(e);
        rx_line = 1'b0; step(64);
        for (int i = 0; i < nd; i++) begin rx_line = val[i]; step(64); end
        if (np) begin rx_line = pbit; step(64); end
        rx_line = stopv;
        if (stopv) step(stop_clks);
        else begin step(64 + extra_low); rx_line = 1'b1; step(stop_clks); end
    endtask

    // correct parity bit for a value under the current configuration
    function automatic bit good_par(input int nd, input logic [7:0] val);
        int ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(val[i]);
        if (cfg_par_stick) return cfg_par_odd;
        return ((ones % 2) == 1) ^ cfg_par_odd;
    endfunction

    initial begin
        step(6);
        // R1: outputs quiet in reset and right after it
        chk({rx_valid, rx_perr, rx_ferr, rx_break} == 4'b0, "R1 reset outputs",
            int'({rx_valid, rx_perr, rx_ferr, rx_break}), 0);
        rst_n = 1'b1;
        step(20);
        chk({rx_valid, rx_perr, rx_ferr, rx_break} == 4'b0, "R1 idle after reset",
            int'({rx_valid, rx_perr, rx_ferr, rx_break}), 0);

        // R3 R10: 8 data bits, no parity
        cfg_bits = 2'd3; cfg_par_en = 0;
        frame(8, 8'hA5, 0, 1, 64, 0);
        frame(8, 8'h3C, 0, 1, 64, 0);
        // R7: null with mark stop is data, not break
        frame(8, 8'h00, 0, 1, 64, 0);
        // R3: 5-bit width, upper bits zero
        cfg_bits = 2'd0;
        frame(5, 8'hF3, 0, 1, 64, 0);
        // R2: short space is rejected, next frame still received
        step(10); rx_line = 1'b0; step(12); rx_line = 1'b1; step(100);
        cfg_bits = 2'd3;
        frame(8, 8'h81, 0, 1, 64, 0);

        // R4: 7 bits even parity good and bad
        cfg_bits = 2'd2; cfg_par_en = 1; cfg_par_odd = 0; cfg_par_stick = 0;
        frame(7, 8'h35, good_par(7, 8'h35), 1, 64, 0);
        frame(7, 8'h35, !good_par(7, 8'h35), 1, 64, 0);
        // R4: 6 bits odd parity good and bad
        cfg_bits = 2'd1; cfg_par_odd = 1;
        frame(6, 8'h2A, good_par(6, 8'h2A), 1, 64, 0);
        frame(6, 8'h2A, !good_par(6, 8'h2A), 1, 64, 0);
        // R5: stick parity, fixed 1 then fixed 0
        cfg_bits = 2'd3; cfg_par_stick = 1; cfg_par_odd = 1;
        frame(8, 8'h07, 1, 1, 64, 0);
        frame(8, 8'h07, 0, 1, 64, 0);
        cfg_par_odd = 0;
        frame(8, 8'h01, 0, 1, 64, 0);
        frame(8, 8'h01, 1, 1, 64, 0);

        // R6: two stop bits and 1.5 stop bits accepted
        cfg_par_en = 0; cfg_par_stick = 0;
        frame(8, 8'h5A, 0, 1, 128, 0);
        frame(8, 8'hC3, 0, 1, 96, 0);
        // R6 R8: framing error, line held at space afterwards: no new start
        frame(8, 8'h41, 0, 0, 64, 300);
        frame(8, 8'h42, 0, 1, 64, 0);
        // R7 R8: break over a whole character and beyond, with parity position
        cfg_par_en = 1; cfg_par_odd = 0;
        frame(8, 8'h00, 0, 0, 64, 500);
        // R7: break without parity
        cfg_par_en = 0;
        frame(8, 8'h00, 0, 0, 64, 200);
        frame(8, 8'h99, 0, 1, 64, 0);

        step(300);
        chk(evq.size() == 0, "R9 all expected reports seen", evq.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule